// File: doc/BRIEF.md
# Banked Serial Port Register File

This block is the register file that a host sees for a 16550-style serial port. It sits on a simple synchronous bus with a 3-bit offset, separate read and write strobes, and 8-bit write and read data. Each access is steered to one of these registers: the receive and transmit holding registers, interrupt enable, interrupt identification, FIFO control, line control, modem control, line status, modem status, a scratch byte, and the two bytes of a 16-bit baud divisor.

Bit 7 of the line control register is a bank switch. It applies to offsets 0 and 1 only. When it is clear, those offsets reach the data registers and the interrupt enable register. When it is set, they reach the divisor bytes. Offset 2 is asymmetric: a read returns the interrupt identification and a write loads FIFO control.

Serial shifting, baud generation, FIFOs and the modem pins are handled outside this block. They appear here as plain handshake and status pins. On both the receive and transmit byte buses, bit 0 is the first bit on the line. A single interrupt output is asserted when any enabled source is pending.

Top module: `uart_regbank`

## Requirements
- R1: Reset state:
  - line control, interrupt enable, modem control, FIFO control, scratch and the divisor all read 0;
  - interrupt identification reads 0x01;
  - line status reads 0x60;
  - `irq` is low.
- R2: With line control bit 7 at 0:
  - a read of offset 0 returns the receive buffer;
  - a write to offset 0 loads the transmit holding register;
  - offset 1 is interrupt enable. Only its low four bits are stored, and its upper bits read 0.
- R3: With line control bit 7 at 1:
  - offset 0 reads and writes the divisor low byte;
  - offset 1 reads and writes the divisor high byte;
  - these writes leave the transmit holding register and interrupt enable unchanged.
- R4: Offset 2 returns interrupt identification on reads and loads FIFO control on writes, for either value of line control bit 7. Identification bits 7:6 read 11 while FIFO control bit 0 is set.
- R5: Offsets 3 to 7 are line control, modem control, line status, modem status and scratch, independent of bit 7. Writes to offsets 5 and 6 are ignored, and offset 6 reads `msr_in`.
- R6: An `rx_valid` pulse copies `rx_byte` into the receive buffer and sets line status bit 0. Reading the receive buffer clears bit 0. A byte that arrives while bit 0 is still set sets line status bit 1 (overrun).
- R7: Writing the transmit holding register raises `tx_hold_valid`, drives the byte on `tx_byte`, and clears line status bit 5. A `tx_take` pulse drops `tx_hold_valid` and sets bit 5 again. Line status bit 6 equals bit 5 AND NOT `tx_busy`.
- R8: `rx_err` bits 0, 1 and 2 (parity, framing, break) set line status bits 2, 3 and 4. Those bits, together with overrun, stay set until line status is read, and the read clears them.
- R9: While interrupt enable bits 3:0 are all 0, `irq` stays low and identification reads 0x01, while line status keeps updating.
- R10: Identification bits 3:0 report the highest pending enabled source, in this priority order:
  - line error (enable bit 2): 0x6;
  - character timeout (enable bit 0, FIFO on, `rx_timeout`): 0xC;
  - data ready (enable bit 0): 0x4;
  - transmit holding empty (enable bit 1): 0x2;
  - modem change (enable bit 3, any of `msr_in[3:0]` set): 0x0.
  
  With nothing pending, bits 3:0 read 0x1. `irq` is high exactly when a source is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (drives read side effects) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current offset |
| irq | output | 1 | Combined interrupt |
| rx_valid | input | 1 | Receive shifter has completed a byte |
| rx_byte | input | 8 | Completed byte, bit 0 received first |
| rx_err | input | 3 | Error pulses: parity, framing, break |
| rx_timeout | input | 1 | Character timeout condition |
| tx_byte | output | 8 | Byte for the transmit shifter, bit 0 sent first |
| tx_hold_valid | output | 1 | Holding register contains a byte |
| tx_take | input | 1 | Shifter loads the holding byte |
| tx_busy | input | 1 | Shifter is still shifting |
| msr_in | input | 8 | Modem status from the pin logic |
| lcr_out | output | 8 | Line control value |
| mcr_out | output | 8 | Modem control value |
| fcr_out | output | 8 | Last FIFO control write |
| divisor_out | output | 16 | Baud divisor |

## Verification
The hardest situation to reach is the interrupt priority ladder, where several sources are pending at once. The stimulus first loads a received byte and a parity error while every enable is off. It then turns all enables on and peels the sources away one at a time:
- a line status read clears the error;
- a receive buffer read clears data ready;
- a holding register write clears transmit empty;
- the modem delta is raised last.

The identification code is checked after each step. The bank switch is tested by writing both divisor bytes while bit 7 is set, then confirming that neither the transmit holding register nor interrupt enable changed.

// File: rtl/uart_regbank_pkg.sv
// Shared widths, offsets, select codes and interrupt codes for the
// banked serial port register file.
package uart_regbank_pkg;
    localparam int DW     = 8;
    localparam int AW     = 3;
    localparam int ERR_W  = 3;
    localparam int DIV_W  = 2 * DW;

    typedef enum logic [AW-1:0] {
        OFS_DATA = 3'd0, OFS_IER = 3'd1, OFS_IIR = 3'd2, OFS_LCR = 3'd3,
        OFS_MCR  = 3'd4, OFS_LSR = 3'd5, OFS_MSR = 3'd6, OFS_SCR = 3'd7
    } ofs_e;

    typedef enum logic [3:0] {
        SEL_RBR, SEL_IER, SEL_DLL, SEL_DLM, SEL_IIR,
        SEL_LCR, SEL_MCR, SEL_LSR, SEL_MSR, SEL_SCR
    } rsel_e;

    typedef struct packed {
        logic thr;
        logic ier;
        logic dll;
        logic dlm;
        logic fcr;
        logic lcr;
        logic mcr;
        logic scr;
    } wstb_t;

    localparam logic [3:0] IIR_NONE  = 4'h1;
    localparam logic [3:0] IIR_LINE  = 4'h6;
    localparam logic [3:0] IIR_TMO   = 4'hC;
    localparam logic [3:0] IIR_RXD   = 4'h4;
    localparam logic [3:0] IIR_THRE  = 4'h2;
    localparam logic [3:0] IIR_MODEM = 4'h0;
endpackage

// File: rtl/uart_bank_decode.sv
// Address decoder. Turns offset, bank bit and strobes into write enables,
// a read-mux select and read side-effect pulses. Purely combinational.
// Assumes bus_wr and bus_rd are never asserted together.
module uart_bank_decode
    import uart_regbank_pkg::*;
(
    input  logic [AW-1:0] addr,
    input  logic          dlab,
    input  logic          wr,
    input  logic          rd,
    output wstb_t         wstb,
    output rsel_e         rsel,
    output logic          rd_rbr,
    output logic          rd_lsr
);
    // Map the offset and bank bit onto one target register.
    always_comb begin
        wstb   = '0;
        rsel   = SEL_SCR;
        rd_rbr = 1'b0;
        rd_lsr = 1'b0;
        case (ofs_e'(addr))
            OFS_DATA: begin
                rsel = dlab ? SEL_DLL : SEL_RBR;
                if (dlab) wstb.dll = wr;
                else      wstb.thr = wr;
                rd_rbr = rd & ~dlab;
            end
            OFS_IER: begin
                rsel = dlab ? SEL_DLM : SEL_IER;
                if (dlab) wstb.dlm = wr;
                else      wstb.ier = wr;
            end
            OFS_IIR: begin
                rsel     = SEL_IIR;
                wstb.fcr = wr;
            end
            OFS_LCR: begin
                rsel     = SEL_LCR;
                wstb.lcr = wr;
            end
            OFS_MCR: begin
                rsel     = SEL_MCR;
                wstb.mcr = wr;
            end
            OFS_LSR: begin
                rsel   = SEL_LSR;
                rd_lsr = rd;
            end
            OFS_MSR: rsel = SEL_MSR;
            default: begin
                rsel     = SEL_SCR;
                wstb.scr = wr;
            end
        endcase
    end
endmodule

// File: rtl/uart_rx_hold.sv
// Receive holding register with the data-ready flag and sticky line errors.
// Assumes rx_valid is a one-cycle pulse from an external shifter.
// err_q bit order: 0 overrun, 1 parity, 2 framing, 3 break.
module uart_rx_hold
    import uart_regbank_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic [DW-1:0]    rx_byte,
    input  logic [ERR_W-1:0] rx_err,
    input  logic             rd_rbr,
    input  logic             rd_lsr,
    output logic [DW-1:0]    rbr_q,
    output logic             dr_q,
    output logic [ERR_W:0]   err_q
);
    logic ovr;

    // Overrun: a new byte arrives while the previous one is still unread.
    assign ovr = rx_valid & dr_q & ~rd_rbr;

    // Capture each received byte and track data ready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbr_q <= '0;
            dr_q  <= 1'b0;
        end else if (rx_valid) begin
            rbr_q <= rx_byte;
            dr_q  <= 1'b1;
        end else if (rd_rbr) begin
            dr_q  <= 1'b0;
        end
    end

    // Hold error flags until line status is read.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= '0;
        else        err_q <= (rd_lsr ? '0 : err_q) | {rx_err, ovr};
    end
endmodule

// File: rtl/uart_tx_hold.sv
// Transmit holding register and its handshake with an external shifter.
// Assumes the shifter pulses tx_take only once its previous byte is done.
module uart_tx_hold
    import uart_regbank_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_thr,
    input  logic [DW-1:0] wdata,
    input  logic          tx_take,
    input  logic          tx_busy,
    output logic [DW-1:0] thr_q,
    output logic          full_q,
    output logic          thre,
    output logic          temt
);
    // Load on a host write; free the slot when the shifter takes the byte.
    // A host write in the same cycle as a take has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_q  <= '0;
            full_q <= 1'b0;
        end else if (we_thr) begin
            thr_q  <= wdata;
            full_q <= 1'b1;
        end else if (tx_take) begin
            full_q <= 1'b0;
        end
    end

    assign thre = ~full_q;
    assign temt = ~full_q & ~tx_busy;
endmodule

// File: rtl/uart_irq_prio.sv
// Interrupt priority encoder. Produces the identification code and the
// combined interrupt from the enable bits and the current conditions.
module uart_irq_prio
    import uart_regbank_pkg::*;
(
    input  logic [3:0]     ier,
    input  logic           fifo_en,
    input  logic [ERR_W:0] err,
    input  logic           dr,
    input  logic           rx_timeout,
    input  logic           thre,
    input  logic [3:0]     msr_delta,
    output logic [DW-1:0]  iir,
    output logic           irq
);
    logic [3:0] code;

    // Walk the sources from highest to lowest priority.
    always_comb begin
        if (ier[2] && |err)                     code = IIR_LINE;
        else if (ier[0] && fifo_en && rx_timeout) code = IIR_TMO;
        else if (ier[0] && dr)                  code = IIR_RXD;
        else if (ier[1] && thre)                code = IIR_THRE;
        else if (ier[3] && |msr_delta)          code = IIR_MODEM;
        else                                    code = IIR_NONE;
    end

    assign iir = {{2{fifo_en}}, 2'b00, code};
    assign irq = (code != IIR_NONE);
endmodule

// File: rtl/uart_regbank.sv
// Banked serial port register file, top level. Holds the host-visible
// control registers, instantiates the decoder, the receive and transmit
// holding logic and the interrupt encoder, and muxes read data.
// Assumes a synchronous single-master bus with no wait states.
module uart_regbank
    import uart_regbank_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    output logic             irq,
    input  logic             rx_valid,
    input  logic [DW-1:0]    rx_byte,
    input  logic [ERR_W-1:0] rx_err,
    input  logic             rx_timeout,
    output logic [DW-1:0]    tx_byte,
    output logic             tx_hold_valid,
    input  logic             tx_take,
    input  logic             tx_busy,
    input  logic [DW-1:0]    msr_in,
    output logic [DW-1:0]    lcr_out,
    output logic [DW-1:0]    mcr_out,
    output logic [DW-1:0]    fcr_out,
    output logic [DIV_W-1:0] divisor_out
);
    logic [DW-1:0]  lcr_q, mcr_q, fcr_q, scr_q, dll_q, dlm_q;
    logic [3:0]     ier_q;
    wstb_t          wstb;
    rsel_e          rsel;
    logic           rd_rbr, rd_lsr;
    logic [DW-1:0]  rbr_q;
    logic           dr_q;
    logic [ERR_W:0] err_q;
    logic           thre, temt;
    logic [DW-1:0]  iir_w, lsr_w;

    uart_bank_decode u_dec (
        .addr(bus_addr), .dlab(lcr_q[7]), .wr(bus_wr), .rd(bus_rd),
        .wstb(wstb), .rsel(rsel), .rd_rbr(rd_rbr), .rd_lsr(rd_lsr)
    );

    uart_rx_hold u_rx (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rx_err(rx_err), .rd_rbr(rd_rbr), .rd_lsr(rd_lsr),
        .rbr_q(rbr_q), .dr_q(dr_q), .err_q(err_q)
    );

    uart_tx_hold u_tx (
        .clk(clk), .rst_n(rst_n), .we_thr(wstb.thr), .wdata(bus_wdata),
        .tx_take(tx_take), .tx_busy(tx_busy), .thr_q(tx_byte),
        .full_q(tx_hold_valid), .thre(thre), .temt(temt)
    );

    uart_irq_prio u_irq (
        .ier(ier_q), .fifo_en(fcr_q[0]), .err(err_q), .dr(dr_q),
        .rx_timeout(rx_timeout), .thre(thre), .msr_delta(msr_in[3:0]),
        .iir(iir_w), .irq(irq)
    );

    // Update the host-writable control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lcr_q <= '0; mcr_q <= '0; fcr_q <= '0; scr_q <= '0;
            dll_q <= '0; dlm_q <= '0; ier_q <= '0;
        end else begin
            if (wstb.lcr) lcr_q <= bus_wdata;
            if (wstb.mcr) mcr_q <= bus_wdata;
            if (wstb.fcr) fcr_q <= bus_wdata;
            if (wstb.scr) scr_q <= bus_wdata;
            if (wstb.dll) dll_q <= bus_wdata;
            if (wstb.dlm) dlm_q <= bus_wdata;
            if (wstb.ier) ier_q <= bus_wdata[3:0];
        end
    end

    assign lsr_w = {1'b0, temt, thre, err_q, dr_q};

    // Select the read data for the decoded register.
    always_comb begin
        case (rsel)
            SEL_RBR: bus_rdata = rbr_q;
            SEL_IER: bus_rdata = {4'b0, ier_q};
            SEL_DLL: bus_rdata = dll_q;
            SEL_DLM: bus_rdata = dlm_q;
            SEL_IIR: bus_rdata = iir_w;
            SEL_LCR: bus_rdata = lcr_q;
            SEL_MCR: bus_rdata = mcr_q;
            SEL_LSR: bus_rdata = lsr_w;
            SEL_MSR: bus_rdata = msr_in;
            default: bus_rdata = scr_q;
        endcase
    end

    assign lcr_out     = lcr_q;
    assign mcr_out     = mcr_q;
    assign fcr_out     = fcr_q;
    assign divisor_out = {dlm_q, dll_q};
endmodule

// File: rtl/uart_regbank_chk.sv
// Assertion checker for the banked register file, bound to the top module.
module uart_regbank_chk
    import uart_regbank_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [AW-1:0]    bus_addr,
    input logic             bus_wr,
    input logic [DW-1:0]    bus_wdata,
    input logic [DW-1:0]    lcr_q,
    input logic [3:0]       ier_q,
    input logic [DW-1:0]    iir_w,
    input logic             irq,
    input logic             rx_valid,
    input logic             dr_q,
    input logic [ERR_W:0]   err_q,
    input logic             tx_take,
    input logic             tx_hold_valid,
    input logic [DW-1:0]    tx_byte,
    input logic [DIV_W-1:0] divisor_out
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (lcr_q == '0 && ier_q == '0 && divisor_out == '0 && !irq));

    // R2
    thr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd0 && !lcr_q[7])
        |=> (tx_hold_valid && tx_byte == $past(bus_wdata)));

    // R3
    dll_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd0 && lcr_q[7])
        |=> (divisor_out[DW-1:0] == $past(bus_wdata)));

    // R6
    rx_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> dr_q);

    // R7
    tx_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_take && tx_hold_valid && !(bus_wr && bus_addr == 3'd0 && !lcr_q[7]))
        |=> !tx_hold_valid);

    // R9
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_q == 4'h0) |-> (!irq && iir_w[3:0] == IIR_NONE));

    // R10
    line_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_q[2] && |err_q) |-> (irq && iir_w[3:0] == IIR_LINE));
endmodule

bind uart_regbank uart_regbank_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .lcr_q(lcr_q), .ier_q(ier_q), .iir_w(iir_w),
    .irq(irq), .rx_valid(rx_valid), .dr_q(dr_q), .err_q(err_q),
    .tx_take(tx_take), .tx_hold_valid(tx_hold_valid), .tx_byte(tx_byte),
    .divisor_out(divisor_out)
);

// File: tb/uart_regbank_test.sv
// Directed bench for the banked register file: one task per scenario.
module uart_regbank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        irq;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic [2:0]  rx_err = '0;
    logic        rx_timeout = 1'b0;
    logic [7:0]  tx_byte;
    logic        tx_hold_valid;
    logic        tx_take = 1'b0, tx_busy = 1'b0;
    logic [7:0]  msr_in = 8'hA0;
    logic [7:0]  lcr_out, mcr_out, fcr_out;
    logic [15:0] divisor_out;
    int checks = 0, fails = 0;
    logic [7:0] d;

    always #4 clk = ~clk;

    uart_regbank uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_err(rx_err),
        .rx_timeout(rx_timeout), .tx_byte(tx_byte),
        .tx_hold_valid(tx_hold_valid), .tx_take(tx_take), .tx_busy(tx_busy),
        .msr_in(msr_in), .lcr_out(lcr_out), .mcr_out(mcr_out),
        .fcr_out(fcr_out), .divisor_out(divisor_out)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] v);
        @(negedge clk); bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic rx_pulse(input logic [7:0] b, input logic [2:0] e, input logic v);
        @(negedge clk); rx_byte = b; rx_err = e; rx_valid = v;
        @(negedge clk); rx_valid = 1'b0; rx_err = '0;
    endtask

    task automatic t_reset;
        rd(3, d); check("R1 lcr", d, 8'h00);
        rd(1, d); check("R1 ier", d, 8'h00);
        rd(2, d); check("R1 iir", d, 8'h01);
        rd(5, d); check("R1 lsr", d, 8'h60);
        rd(7, d); check("R1 scratch", d, 8'h00);
        check("R1 divisor", divisor_out, 16'h0000);
        check("R1 irq", irq, 1'b0);
    endtask

    task automatic t_bank;
        wr(1, 8'hFF); rd(1, d); check("R2 ier upper bits", d, 8'h0F);
        wr(3, 8'h83);
        wr(0, 8'h34); wr(1, 8'h12);
        check("R3 divisor", divisor_out, 16'h1234);
        rd(0, d); check("R3 dll read", d, 8'h34);
        rd(1, d); check("R3 dlm read", d, 8'h12);
        check("R3 thr untouched", tx_hold_valid, 1'b0);
        wr(3, 8'h03);
        rd(1, d); check("R3 ier untouched", d, 8'h0F);
        rd(3, d); check("R5 lcr", d, 8'h03);
        wr(1, 8'h00);
    endtask

    task automatic t_fcr;
        wr(2, 8'hC1); check("R4 fcr write", fcr_out, 8'hC1);
        rd(2, d); check("R4 iir fifo", d, 8'hC1);
        wr(3, 8'h80);
        rd(2, d); check("R4 iir banked", d, 8'hC1);
        wr(3, 8'h03);
        wr(2, 8'h00);
        rd(2, d); check("R4 iir no fifo", d, 8'h01);
    endtask

    task automatic t_regs;
        wr(7, 8'h5A); rd(7, d); check("R5 scratch", d, 8'h5A);
        wr(4, 8'h13); rd(4, d); check("R5 mcr", d, 8'h13);
        check("R5 mcr out", mcr_out, 8'h13);
        wr(5, 8'h00); rd(5, d); check("R5 lsr write ignored", d, 8'h60);
        wr(6, 8'h55); rd(6, d); check("R5 msr readback", d, 8'hA0);
        wr(3, 8'h80);
        wr(7, 8'h3C); rd(7, d); check("R5 scratch banked", d, 8'h3C);
        rd(3, d); check("R5 lcr banked", d, 8'h80);
        wr(3, 8'h03);
    endtask

    task automatic t_rx;
        rx_pulse(8'hA5, 3'b000, 1'b1);
        rd(5, d); check("R6 data ready", d, 8'h61);
        rd(0, d); check("R6 rbr", d, 8'hA5);
        rd(5, d); check("R6 ready cleared", d, 8'h60);
        rx_pulse(8'h01, 3'b000, 1'b1);
        rx_pulse(8'h02, 3'b000, 1'b1);
        rd(5, d); check("R6 overrun", d, 8'h63);
        rd(5, d); check("R8 overrun cleared", d, 8'h61);
        rd(0, d); check("R6 newest byte", d, 8'h02);
        rx_pulse(8'h00, 3'b111, 1'b0);
        rd(5, d); check("R8 errors sticky", d, 8'h7C);
        rd(5, d); check("R8 errors cleared", d, 8'h60);
    endtask

    task automatic t_tx;
        // tx_byte bit 0 is the first bit the shifter sends
        wr(0, 8'h3C);
        check("R7 hold valid", tx_hold_valid, 1'b1);
        check("R7 tx byte", tx_byte, 8'h3C);
        rd(5, d); check("R7 lsr full", d, 8'h00);
        @(negedge clk); tx_busy = 1'b1; tx_take = 1'b1;
        @(negedge clk); tx_take = 1'b0;
        check("R7 taken", tx_hold_valid, 1'b0);
        rd(5, d); check("R7 shifting", d, 8'h20);
        @(negedge clk); tx_busy = 1'b0;
        rd(5, d); check("R7 idle", d, 8'h60);
    endtask

    task automatic t_irq;
        rx_pulse(8'h11, 3'b001, 1'b1);
        check("R9 irq masked", irq, 1'b0);
        rd(2, d); check("R9 iir masked", d, 8'h01);
        wr(1, 8'h0F);
        check("R10 irq line", irq, 1'b1);
        rd(2, d); check("R10 line", d, 8'h06);
        rd(5, d); check("R9 lsr updated", d, 8'h65);
        rd(2, d); check("R10 rx data", d, 8'h04);
        rd(0, d); check("R10 rbr", d, 8'h11);
        rd(2, d); check("R10 thr empty", d, 8'h02);
        wr(0, 8'h77);
        rd(2, d); check("R10 none", d, 8'h01);
        check("R10 irq low", irq, 1'b0);
        @(negedge clk); msr_in = 8'hA1;
        rd(2, d); check("R10 modem", d, 8'h00);
        check("R10 irq modem", irq, 1'b1);
        @(negedge clk); msr_in = 8'hA0;
        wr(2, 8'h01);
        @(negedge clk); rx_timeout = 1'b1;
        rd(2, d); check("R10 timeout", d, 8'hCC);
        @(negedge clk); rx_timeout = 1'b0;
        rd(2, d); check("R4 fifo bits", d, 8'hC1);
        wr(2, 8'h00); wr(1, 8'h00);
        @(negedge clk); tx_take = 1'b1;
        @(negedge clk); tx_take = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog (R1..): actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_bank();
        t_fcr();
        t_regs();
        t_rx();
        t_tx();
        t_irq();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule